// File: doc/BRIEF.md
# LSB-First Serial Register Port

This block lets an external host reach a bank of sixteen 8-bit registers over a four-wire synchronous serial link, while the chip's own logic reads and writes the same registers through a parallel port. The host pulls chip select low and clocks in a control byte. That byte names the operation, the register and the device it is meant for. A write then carries one data byte in on the input line. A read returns the chosen register on the output line, which has its own enable so it can be tri-stated. Both bytes move least significant bit first.

The host's clock, select and data lines are brought into the system clock domain through two-stage synchronizers, and the serial clock edges are found there. The serial clock must therefore run well below the system clock. The chip select and the serial clock are shared with a companion device that uses other values of the select field. For those transactions the port stays silent: it does not write and it does not drive the output.

The core-side port has no back-pressure. A write strobe is taken in the cycle it is high, and read data follows the core address combinationally.

Top module: `lsb_serial_regport`

## Requirements
- R1: After reset, `spi_sdo_oe` is 0 and every register reads 8'h00 on `core_rdata`.
- R2: The first 8 bits after chip select falls form the control byte, LSB first. Bit 0 is read (1) or write (0), bits 4:1 are the register address, and bits 7:5 are the device-select field. The value 3'b001 in that field selects this block.
- R3: On a write, `spi_sdi` is sampled on each rising `spi_sclk`, LSB first. The byte is stored in the addressed register once all 8 data bits have arrived.
- R4: A write whose chip select rises before the eighth data bit leaves every register unchanged.
- R5: On a read, the register's bits appear on `spi_sdo` LSB first with `spi_sdo_oe` high. Each bit changes after a falling `spi_sclk`, the first one after the fall that follows the eighth control bit, and each is valid at the next rising edge.
- R6: After the MSB has been presented, the rising `spi_sclk` that samples it releases `spi_sdo_oe` to 0, even though chip select is still low.
- R7: Whenever `spi_cs_n` is high, `spi_sdo_oe` is 0 in that same cycle, including partway through a read.
- R8: A control byte whose select field is not 3'b001 changes no register, and `spi_sdo_oe` stays 0 for the whole transaction.
- R9: A core write (`core_we`) stores `core_wdata` at `core_addr` on the next clock edge, and later serial reads return that value.
- R10: Extra serial clocks after a completed transaction and before chip select rises have no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial read data |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo (0 = high impedance) |
| core_we | input | 1 | Core write strobe |
| core_addr | input | 4 | Core register address for read and write |
| core_wdata | input | 8 | Core write data |
| core_rdata | output | 8 | Register contents at core_addr |

## Verification
The hardest cases to reach from the pins are those where the host breaks the normal byte rhythm. These include raising chip select in the middle of a returned byte, stopping a write a few bits short, and running more clock pulses after the byte has already finished. The stimulus drives the serial lines bit by bit from tasks that can stop or continue at any bit count. The output enable is sampled at the instant chip select rises, and just after the last rising edge of a read while chip select is still low. A randomized run mixes foreign select fields with reads and writes. It checks every returned byte against a model of the registers.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_CTRL  = 2'd0,
    ST_WDATA = 2'd1,
    ST_READ  = 2'd2,
    ST_SKIP  = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/slp_regbank.sv
module slp_regbank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_we,
  input  logic [ADDR_W-1:0] ser_addr,
  input  logic [DATA_W-1:0] ser_wdata,
  output logic [DATA_W-1:0] ser_rdata,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (ser_we && ser_addr == ADDR_W'(g))
        regs[g] <= ser_wdata;
      else if (core_we && core_addr == ADDR_W'(g))
        regs[g] <= core_wdata;
    end
  end

  assign ser_rdata  = regs[ser_addr];
  assign core_rdata = regs[core_addr];

  // R3: a serial commit lands in the addressed register
  p_ser_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_we |=> regs[$past(ser_addr)] == $past(ser_wdata));

  // R9: a core write lands when no serial commit competes
  p_core_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && !ser_we) |=> regs[$past(core_addr)] == $past(core_wdata));
endmodule

// File: rtl/slp_shifter.sv
module slp_shifter
  import slp_pkg::*;
#(
  parameter int               DATA_W  = 8,
  parameter int               ADDR_W  = 4,
  parameter int               SEL_W   = 3,
  parameter logic [SEL_W-1:0] DEV_SEL = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              drive
);
  localparam int CTL_W = 1 + ADDR_W + SEL_W;
  localparam int MAX_W = (CTL_W > DATA_W) ? CTL_W : DATA_W;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam int TXC_W = $clog2(DATA_W + 1);

  slp_state_e        state_q;
  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] dat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] tx_q;
  logic [TXC_W-1:0]  txc_q;
  logic              sdo_q;
  logic              drive_q;
  logic              wr_en_q;

  logic              rise, fall;
  logic [CTL_W-1:0]  ctl_next;
  logic [DATA_W-1:0] dat_next;
  logic              ctl_rd;
  logic [ADDR_W-1:0] ctl_addr;
  logic [SEL_W-1:0]  ctl_sel;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign ctl_next = {sdi_s, ctl_q[CTL_W-1:1]};
  assign dat_next = {sdi_s, dat_q[DATA_W-1:1]};
  assign ctl_rd   = ctl_next[0];
  assign ctl_addr = ctl_next[ADDR_W:1];
  assign ctl_sel  = ctl_next[CTL_W-1 -: SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CTRL;
      cnt_q   <= '0;
      ctl_q   <= '0;
      dat_q   <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
      txc_q   <= '0;
      sdo_q   <= 1'b0;
      drive_q <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (cs_n_s) begin
        state_q <= ST_CTRL;
        cnt_q   <= '0;
        txc_q   <= '0;
        drive_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_CTRL: if (rise) begin
            ctl_q <= ctl_next;
            if (cnt_q == CNT_W'(CTL_W - 1)) begin
              cnt_q  <= '0;
              addr_q <= ctl_addr;
              if (ctl_sel != DEV_SEL) state_q <= ST_SKIP;
              else if (ctl_rd)        state_q <= ST_READ;
              else                    state_q <= ST_WDATA;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_WDATA: if (rise) begin
            dat_q <= dat_next;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              wr_en_q <= 1'b1;
              state_q <= ST_SKIP;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_READ: begin
            if (fall && txc_q != TXC_W'(DATA_W)) begin
              drive_q <= 1'b1;
              txc_q   <= txc_q + TXC_W'(1);
              if (txc_q == '0) begin
                sdo_q <= rd_data[0];
                tx_q  <= rd_data >> 1;
              end else begin
                sdo_q <= tx_q[0];
                tx_q  <= tx_q >> 1;
              end
            end else if (rise && txc_q == TXC_W'(DATA_W)) begin
              drive_q <= 1'b0;
              state_q <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr = addr_q;
  assign wr_en    = wr_en_q;
  assign wr_data  = dat_q;
  assign sdo      = sdo_q;
  assign drive    = drive_q;

  // R5: output bit moves only after a falling serial clock
  p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo_q));

  // R5: output is driven only while a read is in progress
  p_drive_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> state_q == ST_READ);

  // R6: the rising edge after the MSB releases the line
  p_release_after_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && txc_q == TXC_W'(DATA_W) && rise && !cs_n_s) |=> !drive_q);

  // R7: deselect ends any drive and rearms the control phase
  p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (!drive_q && state_q == ST_CTRL));

  // R10: at most one commit per transaction
  p_single_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q);
endmodule

// File: rtl/lsb_serial_regport.sv
module lsb_serial_regport #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata
);
  localparam logic [SEL_W-1:0] DEV_SEL = SEL_W'(1);

  logic              cs_n_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] reg_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              sdo_q, drive_q;

  slp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(cs_n_s));
  slp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
  slp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d(spi_sdi), .q(sdi_s));

  slp_shifter #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DEV_SEL(DEV_SEL)
  ) u_shifter (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data),
    .sdo(sdo_q), .drive(drive_q)
  );

  slp_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regbank (
    .clk(clk), .rst_n(rst_n),
    .ser_we(wr_en), .ser_addr(reg_addr), .ser_wdata(wr_data), .ser_rdata(rd_data),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata)
  );

  assign spi_sdo    = sdo_q;
  assign spi_sdo_oe = drive_q & ~spi_cs_n;
endmodule

// File: tb/test_lsb_serial_regport.sv
module test_lsb_serial_regport;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, oe;
  logic       core_we = 1'b0;
  logic [3:0] core_addr = '0;
  logic [7:0] core_wdata = '0;
  logic [7:0] core_rdata;

  int errors = 0, checks = 0;
  int oe_hits = 0;
  logic [7:0] model [16];

  lsb_serial_regport i_lsb_serial_regport (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(oe),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (oe === 1'b1) oe_hits++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_ctl(input logic [2:0] sel, input logic [3:0] a, input logic rd);
    return {sel, a, rd};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_off();
    tick(HALF);
    cs_n = 1'b1;
    tick(3 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = v[i];
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic recv_byte(input int nb, output logic [7:0] got, output int oe_miss, output logic oe_after);
    got = '0;
    oe_miss = 0;
    oe_after = 1'b0;
    sdi = 1'b0;
    for (int i = 0; i < nb; i++) begin
      tick(HALF);
      if (oe !== 1'b1) oe_miss++;
      got[i] = sdo;
      sclk = 1'b1;
      tick(HALF);
      if (i == 7) oe_after = oe;
      sclk = 1'b0;
    end
  endtask

  task automatic ser_write(input logic [2:0] sel, input logic [3:0] a, input logic [7:0] d, input int nbits);
    cs_on();
    send_bits(mk_ctl(sel, a, 1'b0), 8);
    send_bits(d, nbits);
    cs_off();
  endtask

  task automatic ser_read(input logic [2:0] sel, input logic [3:0] a, output logic [7:0] got,
                          output int oe_miss, output logic oe_after);
    cs_on();
    send_bits(mk_ctl(sel, a, 1'b1), 8);
    recv_byte(8, got, oe_miss, oe_after);
    cs_off();
  endtask

  task automatic core_read(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    core_addr = a;
    #1 v = core_rdata;
  endtask

  task automatic core_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    core_we = 1'b1; core_addr = a; core_wdata = d;
    @(negedge clk);
    core_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v, got;
    int miss;
    logic after;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = 8'h00;

    tick(3);
    chk("R1 oe in reset", {31'd0, oe}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 oe after reset", {31'd0, oe}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      core_read(4'(i), v);
      chk("R1 register reset value", {24'd0, v}, 32'd0);
    end

    // R2/R3: directed write, verified through the core port
    ser_write(3'b001, 4'd5, 8'hA5, 8); model[5] = 8'hA5;
    core_read(4'd5, v);
    chk("R3 serial write stored", {24'd0, v}, 32'hA5);
    ser_write(3'b001, 4'd14, 8'h01, 8); model[14] = 8'h01;
    core_read(4'd14, v);
    chk("R2 address field bits 4:1", {24'd0, v}, 32'h01);

    // R5/R6: directed read
    oe_hits = 0;
    ser_read(3'b001, 4'd5, got, miss, after);
    chk("R5 read data LSB first", {24'd0, got}, 32'hA5);
    chk("R5 oe high at every sample", miss, 0);
    chk("R6 oe released after MSB with cs low", {31'd0, after}, 32'd0);

    // R9: core write visible over the serial side
    core_write(4'd9, 8'h3C); model[9] = 8'h3C;
    ser_read(3'b001, 4'd9, got, miss, after);
    chk("R9 core write read serially", {24'd0, got}, 32'h3C);

    // R4: truncated write
    ser_write(3'b001, 4'd5, 8'hFF, 5);
    core_read(4'd5, v);
    chk("R4 truncated write ignored", {24'd0, v}, 32'hA5);
    ser_write(3'b001, 4'd6, 8'hFF, 7);
    core_read(4'd6, v);
    chk("R4 seven-bit write ignored", {24'd0, v}, 32'h00);

    // R8: foreign select field
    ser_write(3'b010, 4'd5, 8'h11, 8);
    core_read(4'd5, v);
    chk("R8 foreign write ignored", {24'd0, v}, 32'hA5);
    oe_hits = 0;
    ser_read(3'b000, 4'd5, got, miss, after);
    chk("R8 foreign read never drives", oe_hits, 0);
    oe_hits = 0;
    ser_read(3'b101, 4'd9, got, miss, after);
    chk("R8 foreign read never drives", oe_hits, 0);

    // R10: extra clocks after a complete write
    cs_on();
    send_bits(mk_ctl(3'b001, 4'd2, 1'b0), 8);
    send_bits(8'h77, 8);
    send_bits(8'h88, 8);
    send_bits(8'h99, 8);
    cs_off();
    model[2] = 8'h77;
    core_read(4'd2, v);
    chk("R10 extra bits ignored", {24'd0, v}, 32'h77);

    // R7: chip select raised in mid-read
    cs_on();
    send_bits(mk_ctl(3'b001, 4'd9, 1'b1), 8);
    recv_byte(3, got, miss, after);
    tick(HALF);
    chk("R7 oe high before abort", {31'd0, oe}, 32'd1);
    cs_n = 1'b1;
    #1 chk("R7 oe drops with cs", {31'd0, oe}, 32'd0);
    oe_hits = 0;
    tick(3 * HALF);
    chk("R7 oe stays low after abort", oe_hits, 0);
    ser_read(3'b001, 4'd9, got, miss, after);
    chk("R7 next read after abort", {24'd0, got}, 32'h3C);

    // randomized mix
    for (int t = 0; t < 60; t++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic [2:0] sel;
      bit rd;
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      rd = 1'($urandom);
      sel = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b001;
      if (rd) begin
        oe_hits = 0;
        ser_read(sel, a, got, miss, after);
        if (sel == 3'b001) begin
          chk("R5 random read", {24'd0, got}, {24'd0, model[a]});
          chk("R6 random release", {31'd0, after}, 32'd0);
        end else begin
          chk("R8 random foreign read", oe_hits, 0);
        end
      end else begin
        ser_write(sel, a, d, 8);
        if (sel == 3'b001) model[a] = d;
      end
    end
    for (int i = 0; i < 16; i++) begin
      core_read(4'(i), v);
      chk("R3 final register image", {24'd0, v}, {24'd0, model[i]});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule